// File: doc/BRIEF.md
# Transfer Byte Counter with Zero and Illegal-Length Detection

This block keeps the remaining byte count of a block-move data transfer. A load fills a 24-bit count register from one of three sources: a register write, the low field of a fetched instruction word, or a table-indirect offset. A load can also be marked as a block-move instruction. After the load, every completed bus data beat reports how many bytes it moved, from one to four. The count drops by exactly that amount.

The block flags three events. A done pulse marks the beat that brings a nonzero count to zero. An overrun pulse marks a beat that reports more bytes than remain; the count then saturates at zero. An illegal-length pulse marks a block-move load of zero, unless the device is acting as a target in command phase. A level output shows whenever the count reads zero. Instruction decoding, bus protocol and interrupt handling live in neighbouring blocks.

Top module: `xfer_byte_counter`

## Requirements
- R1: While reset is asserted and in the first cycle after release, done, overrun and illegal are all low. The count value is not defined until the first load.
- R2: A load with source select 0 (register write) makes count equal wr_data on the next cycle.
- R3: A load with source select 1 (fetch) makes count equal fetch_field on the next cycle.
- R4: A load with source select 2 (table offset) makes count equal tbl_offset on the next cycle.
- R5: A load request with source select 3 is ignored. The count does not change from it and it raises no illegal pulse, but a valid beat in the same cycle still applies.
- R6: A beat with beat_bytes from 1 to 4 that does not exceed the count lowers count by beat_bytes on the next cycle.
- R7: A beat with beat_bytes equal to 0 or greater than 4 is ignored. Count and all flags behave as if no beat occurred.
- R8: When a valid load and a valid beat arrive in the same cycle, the load wins and the beat is discarded.
- R9: done is high for exactly the one cycle after a beat that takes a nonzero count to zero, and is low otherwise.
- R10: A valid beat with beat_bytes greater than the count sets count to zero and pulses overrun high for one cycle.
- R11: A valid load with ld_is_bmov high and a loaded value of zero pulses illegal for one cycle, unless tgt_cmd_phase is high. Any other load raises no illegal pulse.
- R12: count_zero is high exactly when count equals zero, in the same cycle.
- R13: The full value 0xFFFFFF loads and decrements without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load request |
| ld_src | input | 2 | Load source: 0 register write, 1 fetch field, 2 table offset, 3 reserved |
| wr_data | input | 24 | Register write value |
| fetch_field | input | 24 | Low 24 bits of the fetched instruction word |
| tbl_offset | input | 24 | Table-indirect offset |
| ld_is_bmov | input | 1 | The load belongs to a block-move instruction |
| tgt_cmd_phase | input | 1 | Device is a target in command phase |
| beat_vld | input | 1 | A bus data beat completed |
| beat_bytes | input | 3 | Bytes moved by the beat (1 to 4 valid) |
| count | output | 24 | Remaining byte count |
| count_zero | output | 1 | Count equals zero |
| done | output | 1 | One-cycle pulse: count reached zero |
| overrun | output | 1 | One-cycle pulse: beat exceeded remaining count |
| illegal | output | 1 | One-cycle pulse: zero-length block-move load |

## Verification
Count, done, overrun and illegal each come from a register, so each one answers a load or beat exactly one clock edge later. count_zero follows count within that same cycle. The bench applies inputs just after the rising edge. At each falling edge it compares all five outputs with a behavioural model. That model was advanced at the previous falling edge from the inputs that had been applied, so every comparison falls in the cycle the result is due. Count comparisons begin only after the first load, because the count is undefined until then.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
  typedef enum logic [1:0] {
    SRC_REGW  = 2'd0,
    SRC_FETCH = 2'd1,
    SRC_TABLE = 2'd2,
    SRC_RSVD  = 2'd3
  } ld_src_e;
endpackage

// File: rtl/xbc_load_mux.sv
module xbc_load_mux
  import xbc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             ld_en,
  input  logic [1:0]       ld_src,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] fetch_field,
  input  logic [CNT_W-1:0] tbl_offset,
  output logic             ld_valid,
  output logic [CNT_W-1:0] ld_value
);
  ld_src_e src;

  always_comb begin
    src      = ld_src_e'(ld_src);
    ld_valid = 1'b0;
    ld_value = '0;
    if (ld_en) begin
      unique case (src)
        SRC_REGW:  begin ld_valid = 1'b1; ld_value = wr_data;     end
        SRC_FETCH: begin ld_valid = 1'b1; ld_value = fetch_field; end
        SRC_TABLE: begin ld_valid = 1'b1; ld_value = tbl_offset;  end
        default:   begin ld_valid = 1'b0; ld_value = '0;          end
      endcase
    end
  end
endmodule

// File: rtl/xbc_step.sv
module xbc_step #(
  parameter int CNT_W    = 24,
  parameter int MAX_BEAT = 4,
  parameter int BEAT_W   = $clog2(MAX_BEAT + 1)
) (
  input  logic              beat_vld,
  input  logic [BEAT_W-1:0] beat_bytes,
  input  logic [CNT_W-1:0]  cur_count,
  output logic              step_valid,
  output logic              step_over,
  output logic [CNT_W-1:0]  step_next
);
  localparam int PAD_W = CNT_W - BEAT_W;
  localparam logic [BEAT_W-1:0] MAX_B = BEAT_W'(MAX_BEAT);

  logic [CNT_W-1:0] bytes_ext;
  logic             in_range;

  always_comb begin
    bytes_ext  = {{PAD_W{1'b0}}, beat_bytes};
    in_range   = (beat_bytes != '0) && (beat_bytes <= MAX_B);
    step_valid = beat_vld && in_range;
    step_over  = step_valid && (bytes_ext > cur_count);
    if (bytes_ext > cur_count) begin
      step_next = '0;
    end else begin
      step_next = cur_count - bytes_ext;
    end
  end
endmodule

// File: rtl/xfer_byte_counter.sv
module xfer_byte_counter #(
  parameter int CNT_W    = 24,
  parameter int MAX_BEAT = 4,
  parameter int BEAT_W   = $clog2(MAX_BEAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [1:0]        ld_src,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [CNT_W-1:0]  fetch_field,
  input  logic [CNT_W-1:0]  tbl_offset,
  input  logic              ld_is_bmov,
  input  logic              tgt_cmd_phase,
  input  logic              beat_vld,
  input  logic [BEAT_W-1:0] beat_bytes,
  output logic [CNT_W-1:0]  count,
  output logic              count_zero,
  output logic              done,
  output logic              overrun,
  output logic              illegal
);
  logic             ld_valid;
  logic [CNT_W-1:0] ld_value;
  logic             step_valid;
  logic             step_over;
  logic [CNT_W-1:0] step_next;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             done_q, done_d;
  logic             over_q, over_d;
  logic             ill_q, ill_d;

  xbc_load_mux #(.CNT_W(CNT_W)) u_load (
    .ld_en       (ld_en),
    .ld_src      (ld_src),
    .wr_data     (wr_data),
    .fetch_field (fetch_field),
    .tbl_offset  (tbl_offset),
    .ld_valid    (ld_valid),
    .ld_value    (ld_value)
  );

  xbc_step #(.CNT_W(CNT_W), .MAX_BEAT(MAX_BEAT), .BEAT_W(BEAT_W)) u_step (
    .beat_vld   (beat_vld),
    .beat_bytes (beat_bytes),
    .cur_count  (cnt_q),
    .step_valid (step_valid),
    .step_over  (step_over),
    .step_next  (step_next)
  );

  // next-state
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    done_d = 1'b0;
    over_d = 1'b0;
    ill_d  = 1'b0;
    if (ld_valid) begin
      cnt_en = 1'b1;
      cnt_d  = ld_value;
      ill_d  = ld_is_bmov && (ld_value == '0) && !tgt_cmd_phase;
    end else if (step_valid) begin
      cnt_en = 1'b1;
      cnt_d  = step_next;
      done_d = (cnt_q != '0) && (step_next == '0);
      over_d = step_over;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      over_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      over_q <= over_d;
      ill_q  <= ill_d;
    end
  end

  assign count      = cnt_q;
  assign count_zero = (cnt_q == '0);
  assign done       = done_q;
  assign overrun    = over_q;
  assign illegal    = ill_q;
endmodule

// File: rtl/xbc_chk.sv
module xbc_chk #(
  parameter int CNT_W    = 24,
  parameter int MAX_BEAT = 4,
  parameter int BEAT_W   = $clog2(MAX_BEAT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_en,
  input logic [1:0]        ld_src,
  input logic [CNT_W-1:0]  wr_data,
  input logic [CNT_W-1:0]  fetch_field,
  input logic [CNT_W-1:0]  tbl_offset,
  input logic              ld_is_bmov,
  input logic              tgt_cmd_phase,
  input logic              beat_vld,
  input logic [BEAT_W-1:0] beat_bytes,
  input logic [CNT_W-1:0]  count,
  input logic              count_zero,
  input logic              done,
  input logic              overrun,
  input logic              illegal
);
  logic load_any;
  logic beat_ok;
  assign load_any = ld_en && (ld_src != 2'd3);
  assign beat_ok  = beat_vld && (beat_bytes != '0) && (int'(beat_bytes) <= MAX_BEAT);

  // R2
  regw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_src == 2'd0) |=> (count == $past(wr_data)));
  // R3
  fetch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_src == 2'd1) |=> (count == $past(fetch_field)));
  // R4
  table_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_src == 2'd2) |=> (count == $past(tbl_offset)));
  // R7
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_any && !beat_ok) |=> ($stable(count) && !done && !overrun));
  // R6
  beat_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_any && beat_ok && CNT_W'(beat_bytes) <= count)
      |=> (count == $past(count) - CNT_W'($past(beat_bytes))));
  // R9
  done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (count == '0 && $past(count) != '0));
  // R10
  overrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> (count == '0));
  // R11
  illegal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> ($past(load_any) && $past(ld_is_bmov) && !$past(tgt_cmd_phase) && count == '0));
  // R12
  zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_zero == (count == '0));
  // R9
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind xfer_byte_counter xbc_chk #(
  .CNT_W(CNT_W), .MAX_BEAT(MAX_BEAT), .BEAT_W(BEAT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_src(ld_src),
  .wr_data(wr_data), .fetch_field(fetch_field), .tbl_offset(tbl_offset),
  .ld_is_bmov(ld_is_bmov), .tgt_cmd_phase(tgt_cmd_phase),
  .beat_vld(beat_vld), .beat_bytes(beat_bytes), .count(count),
  .count_zero(count_zero), .done(done), .overrun(overrun), .illegal(illegal)
);

// File: tb/xfer_byte_counter_tb.sv
`timescale 1ns/1ps
module xfer_byte_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en;
  logic [1:0]  ld_src;
  logic [23:0] wr_data, fetch_field, tbl_offset;
  logic        ld_is_bmov, tgt_cmd_phase, beat_vld;
  logic [2:0]  beat_bytes;
  logic [23:0] count;
  logic        count_zero, done, overrun, illegal;

  int vectors = 0;
  int fails   = 0;
  string cur_req = "R1";

  // reference model state
  int  m_cnt = 0;
  bit  m_known = 0;
  bit  m_done = 0, m_over = 0, m_ill = 0;

  always #2.5 clk = ~clk;

  xfer_byte_counter dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_src(ld_src),
    .wr_data(wr_data), .fetch_field(fetch_field), .tbl_offset(tbl_offset),
    .ld_is_bmov(ld_is_bmov), .tgt_cmd_phase(tgt_cmd_phase),
    .beat_vld(beat_vld), .beat_bytes(beat_bytes), .count(count),
    .count_zero(count_zero), .done(done), .overrun(overrun), .illegal(illegal)
  );

  task automatic check(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  // compare, then advance the model with the inputs now applied
  always @(negedge clk) begin
    if (!rst_n) begin
      m_done = 0; m_over = 0; m_ill = 0;
    end else begin
      check("done", int'(done), int'(m_done));
      check("overrun", int'(overrun), int'(m_over));
      check("illegal", int'(illegal), int'(m_ill));
      if (m_known) begin
        check("count", int'(count), m_cnt);
        check("count_zero", int'(count_zero), int'(m_cnt == 0)); // R12
      end
      m_done = 0; m_over = 0; m_ill = 0;
      if (ld_en && ld_src != 2'd3) begin
        int v;
        v = (ld_src == 2'd0) ? int'(wr_data) :
            (ld_src == 2'd1) ? int'(fetch_field) : int'(tbl_offset);
        m_cnt = v; m_known = 1;
        m_ill = ld_is_bmov && (v == 0) && !tgt_cmd_phase;
      end else if (beat_vld && beat_bytes >= 3'd1 && beat_bytes <= 3'd4) begin
        int b, nv;
        b = int'(beat_bytes);
        if (b > m_cnt) begin nv = 0; m_over = 1; end
        else nv = m_cnt - b;
        m_done = (m_cnt != 0) && (nv == 0);
        m_cnt = nv;
      end
    end
  end

  task automatic idle_inputs();
    ld_en = 0; ld_src = 0; wr_data = 0; fetch_field = 0; tbl_offset = 0;
    ld_is_bmov = 0; tgt_cmd_phase = 0; beat_vld = 0; beat_bytes = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic load(input logic [1:0] src, input logic [23:0] v,
                      input logic bmov, input logic tgt);
    ld_en = 1; ld_src = src; ld_is_bmov = bmov; tgt_cmd_phase = tgt;
    wr_data = 24'h5A5A5A; fetch_field = 24'hA5A5A5; tbl_offset = 24'h3C3C3C;
    case (src)
      2'd0: wr_data = v;
      2'd1: fetch_field = v;
      default: tbl_offset = v;
    endcase
    tick();
  endtask

  task automatic beat(input logic [2:0] b);
    beat_vld = 1; beat_bytes = b;
    tick();
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cur_req = "R1"; tick(); tick();
    cur_req = "R2"; load(2'd0, 24'h000010, 0, 0); tick();
    cur_req = "R6"; beat(3'd4); beat(3'd1); beat(3'd3); tick();
    cur_req = "R7"; beat(3'd0); beat(3'd5); beat(3'd7); tick();
    cur_req = "R9"; beat(3'd4); beat(3'd4); tick(); tick();
    cur_req = "R10"; load(2'd0, 24'd5, 0, 0); beat(3'd4); beat(3'd4); tick();
    beat(3'd2); tick();
    cur_req = "R3"; load(2'd1, 24'h123456, 0, 0); tick();
    cur_req = "R4"; load(2'd2, 24'h000100, 0, 0); tick();
    cur_req = "R5"; load(2'd3, 24'h000000, 1, 0); tick();
    ld_en = 1; ld_src = 2'd3; wr_data = 24'h777777; beat_vld = 1; beat_bytes = 3'd2; tick();
    cur_req = "R8";
    ld_en = 1; ld_src = 2'd0; wr_data = 24'h000003; beat_vld = 1; beat_bytes = 3'd1; tick();
    tick();
    cur_req = "R11"; load(2'd0, 24'd0, 1, 0); tick();
    load(2'd2, 24'd0, 1, 1); tick();
    load(2'd1, 24'd0, 0, 0); tick();
    load(2'd0, 24'd9, 1, 0); tick();
    cur_req = "R13"; load(2'd0, 24'hFFFFFF, 1, 0); beat(3'd4); beat(3'd3); tick();
    cur_req = "R12"; load(2'd0, 24'd1, 0, 0); beat(3'd1); tick(); tick();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule